// File: doc/BRIEF.md
# Textured Primitive Command Decoder

This block sits at the front of a texture-mapping draw pipeline. It takes a stream of 32-bit command words over a valid/ready handshake. The top byte of each leading word selects the command. Triangle, quad and rectangle commands are followed by a fixed number of parameter words. The block gathers these words and emits one record for each triangle or rectangle that can be drawn. Two single-word commands update the persistent texture-page and texture-window settings. Any other leading word is swallowed and has no effect.

A record carries up to three vertices with their positions and texel coordinates, the palette location word, the page settings that apply to this primitive, the semi-transparency flag, the 24-bit modulation colour, and the rectangle size. Polygons bring their own page settings in their second texel word, and those settings also become the persistent page state. Rectangles use the persistent page state. A quad leaves the block as two triangles in a fixed vertex order. While a record waits on the output handshake, no new command word is accepted.

Top module: `tex_cmd_decoder`

## Requirements
- R1: After reset `cmd_ready` is 1, `prim_valid` is 0, and `page_cfg` and `win_cfg` are 0.
- R2: Leading byte 0x24 is followed by six words: position, texel, position, texel, position, texel. It yields one record with `prim_rect`=0 and `prim_second`=0. `prim_color` is bits 23..0 of the leading word. A position word holds Y in bits 31..16 and X in bits 15..0. A texel word holds V in bits 15..8 and U in bits 7..0. `prim_pal` is bits 31..16 of the first texel word. `prim_page` is bits 8..0 of the upper half of the second texel word. Vertex k occupies `prim_xy[32k+31:32k]` and `prim_uv[16k+15:16k]`.
- R3: Leading bytes 0x2C and 0x2E are followed by eight words in the same pattern, describing four vertices. They yield two records. The first record holds vertices (0,1,2) with `prim_second`=0. The second holds vertices (1,2,3) with `prim_second`=1.
- R4: Leading bytes 0x64 and 0x66 are followed by three words: top-left position, then a word with palette in bits 31..16 and texel in bits 15..0, then height in bits 31..16 and width in bits 15..0. They yield one record with `prim_rect`=1 and `prim_size` equal to that last word. Vertex 0 carries the position and texel, and vertices 1 and 2 read as zero. `prim_page` equals the persistent `page_cfg[8:0]`.
- R5: `prim_semi` equals bit 1 of the leading byte.
- R6: Leading byte 0xE1 copies bits 10..0 into `page_cfg` and produces no record. Within those bits, page X is 3..0, page Y is 4, blend mode is 6..5, depth is 8..7, dither is 9 and display-area drawing is 10.
- R7: Leading byte 0xE2 copies bits 19..0 into `win_cfg` and produces no record. Mask X is in bits 4..0, mask Y in 9..5, offset X in 14..10 and offset Y in 19..15.
- R8: The embedded page field of a triangle or quad replaces `page_cfg[8:0]` and leaves `page_cfg[10:9]` unchanged.
- R9: `prim_pal_unused` is 1 exactly when depth bit 1 of the record's page settings is set (`prim_page[8]`), which is the direct-colour depth.
- R10: Any other leading byte is consumed as a single word. It produces no record and changes neither `page_cfg` nor `win_cfg`.
- R11: While `prim_valid` is 1, `cmd_ready` is 0. Every record output holds steady until `prim_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command word offered |
| cmd_data | input | 32 | Command word |
| cmd_ready | output | 1 | Command word accepted on this edge when valid |
| prim_valid | output | 1 | Record available |
| prim_ready | input | 1 | Record taken by the consumer |
| prim_xy | output | 96 | Three vertex positions, vertex k at bits 32k+31..32k |
| prim_uv | output | 48 | Three texel coordinates, vertex k at bits 16k+15..16k |
| prim_color | output | 24 | Modulation colour |
| prim_pal | output | 16 | Palette location word |
| prim_pal_unused | output | 1 | Palette not used at the record's depth |
| prim_page | output | 9 | Page X, page Y, blend mode and depth for this record |
| prim_semi | output | 1 | Semi-transparent primitive |
| prim_rect | output | 1 | Record is a rectangle |
| prim_second | output | 1 | Record is the second triangle of a quad |
| prim_size | output | 32 | Rectangle height (31..16) and width (15..0) |
| page_cfg | output | 11 | Persistent page state |
| win_cfg | output | 20 | Persistent texture-window state |

## Verification
The bench targets the places where the state comes from more than one source. A rectangle sent after a polygon must pick up the polygon's embedded page. A design that kept only the 0xE1 value would show a stale blend mode and depth. The page bits 10..9 must survive a polygon update, and a design that copied all eleven bits would clear them. The bench holds back the output handshake to test that records stay steady and that input is blocked. It checks the vertex shift between the two halves of a quad. A wrong shift shows up as the wrong vertices in the second record.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  localparam int WORD_W  = 32;
  localparam int NVERT   = 4;
  localparam int OUT_V   = 3;
  localparam int XY_W    = 32;
  localparam int UV_W    = 16;
  localparam int PAGE_W  = 11;
  localparam int EPAGE_W = 9;
  localparam int WIN_W   = 20;
  localparam int IDX_W   = 4;

  typedef enum logic [2:0] {
    K_NONE, K_TRI, K_QUAD, K_RECT, K_PAGE, K_WIN
  } kind_t;

  typedef enum logic [1:0] {
    S_IDLE, S_COLLECT, S_EMIT_A, S_EMIT_B
  } st_t;

  function automatic kind_t classify(input logic [7:0] op);
    case (op)
      8'h24:          return K_TRI;
      8'h2C, 8'h2E:   return K_QUAD;
      8'h64, 8'h66:   return K_RECT;
      8'hE1:          return K_PAGE;
      8'hE2:          return K_WIN;
      default:        return K_NONE;
    endcase
  endfunction

  // Index of the final word of a command (leading word is index 0).
  function automatic logic [IDX_W-1:0] last_index(input kind_t k);
    case (k)
      K_TRI:   return IDX_W'(6);
      K_QUAD:  return IDX_W'(8);
      K_RECT:  return IDX_W'(3);
      default: return IDX_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/tcd_state_regs.sv
module tcd_state_regs
  import tcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               page_wr,
  input  logic               poly_page_wr,
  input  logic               win_wr,
  input  logic [PAGE_W-1:0]  page_data,
  input  logic [EPAGE_W-1:0] poly_page,
  input  logic [WIN_W-1:0]   win_data,
  output logic [PAGE_W-1:0]  page_q,
  output logic [WIN_W-1:0]   win_q
);

  logic [PAGE_W-1:0] page_d;
  logic [WIN_W-1:0]  win_d;
  logic              page_en;

  always_comb begin
    page_en = page_wr | poly_page_wr;
    page_d  = page_q;
    if (page_wr)
      page_d = page_data;
    else if (poly_page_wr)
      page_d = {page_q[PAGE_W-1:EPAGE_W], poly_page};
    win_d = win_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      win_q  <= '0;
    end else begin
      if (page_en) page_q <= page_d;
      if (win_wr)  win_q  <= win_d;
    end
  end

endmodule

// File: rtl/tcd_collector.sv
module tcd_collector
  import tcd_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [WORD_W-1:0]          cmd_data,
  output logic                       cmd_ready,
  input  logic                       prim_ready,
  output logic                       in_idle,
  output logic                       emitting,
  output logic                       second,
  output logic                       is_rect,
  output logic                       semi,
  output logic [23:0]                color,
  output logic [15:0]                pal,
  output logic [EPAGE_W-1:0]         emb_page,
  output logic [WORD_W-1:0]          size,
  output logic [NVERT-1:0][XY_W-1:0] xy,
  output logic [NVERT-1:0][UV_W-1:0] uv,
  output logic                       page_wr,
  output logic                       poly_page_wr,
  output logic                       win_wr
);

  st_t              st_q, st_d;
  kind_t            kind_q, k_in;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             accept;
  logic             hdr_we, pal_we, emb_we, size_we;
  logic [NVERT-1:0] xy_we, uv_we;
  logic [2:0]       half;
  logic [1:0]       xy_slot, uv_slot;

  assign cmd_ready = (st_q == S_IDLE) || (st_q == S_COLLECT);
  assign accept    = cmd_valid && cmd_ready;
  assign k_in      = classify(cmd_data[31:24]);
  assign half      = idx_q[3:1];
  assign xy_slot   = half[1:0];
  assign uv_slot   = 2'(half - 3'd1);

  always_comb begin
    st_d = st_q;
    idx_d = idx_q;
    hdr_we = 1'b0; pal_we = 1'b0; emb_we = 1'b0; size_we = 1'b0;
    xy_we = '0; uv_we = '0;
    page_wr = 1'b0; poly_page_wr = 1'b0; win_wr = 1'b0;
    case (st_q)
      S_IDLE: if (accept) begin
        case (k_in)
          K_TRI, K_QUAD, K_RECT: begin
            hdr_we = 1'b1;
            idx_d  = IDX_W'(1);
            st_d   = S_COLLECT;
          end
          K_PAGE:  page_wr = 1'b1;
          K_WIN:   win_wr  = 1'b1;
          default: ;
        endcase
      end
      S_COLLECT: if (accept) begin
        idx_d = idx_q + IDX_W'(1);
        if (kind_q == K_RECT) begin
          xy_we[0] = (idx_q == IDX_W'(1));
          uv_we[0] = (idx_q == IDX_W'(2));
          pal_we   = (idx_q == IDX_W'(2));
          size_we  = (idx_q == IDX_W'(3));
        end else begin
          if (idx_q[0]) xy_we[xy_slot] = 1'b1;
          else          uv_we[uv_slot] = 1'b1;
          pal_we = (idx_q == IDX_W'(2));
          if (idx_q == IDX_W'(4)) begin
            emb_we       = 1'b1;
            poly_page_wr = 1'b1;
          end
        end
        if (idx_q == last_index(kind_q)) st_d = S_EMIT_A;
      end
      S_EMIT_A: if (prim_ready)
        st_d = (kind_q == K_QUAD) ? S_EMIT_B : S_IDLE;
      S_EMIT_B: if (prim_ready) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      kind_q <= K_NONE;
      semi   <= 1'b0;
      color  <= '0;
      pal    <= '0;
      emb_page <= '0;
      size   <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (hdr_we) begin
        kind_q <= k_in;
        semi   <= cmd_data[25];
        color  <= cmd_data[23:0];
      end
      if (pal_we)  pal      <= cmd_data[31:16];
      if (emb_we)  emb_page <= cmd_data[16 +: EPAGE_W];
      if (size_we) size     <= cmd_data;
    end
  end

  for (genvar g = 0; g < NVERT; g++) begin : g_vert
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xy[g] <= '0;
        uv[g] <= '0;
      end else begin
        if (xy_we[g]) xy[g] <= cmd_data;
        if (uv_we[g]) uv[g] <= cmd_data[UV_W-1:0];
      end
    end
  end

  assign in_idle  = (st_q == S_IDLE);
  assign emitting = (st_q == S_EMIT_A) || (st_q == S_EMIT_B);
  assign second   = (st_q == S_EMIT_B);
  assign is_rect  = (kind_q == K_RECT);

endmodule

// File: rtl/tcd_record_mux.sv
module tcd_record_mux
  import tcd_pkg::*;
(
  input  logic                       second,
  input  logic                       is_rect,
  input  logic [NVERT-1:0][XY_W-1:0] xy,
  input  logic [NVERT-1:0][UV_W-1:0] uv,
  input  logic [EPAGE_W-1:0]         emb_page,
  input  logic [PAGE_W-1:0]          page_cfg,
  output logic [OUT_V*XY_W-1:0]      prim_xy,
  output logic [OUT_V*UV_W-1:0]      prim_uv,
  output logic [EPAGE_W-1:0]         prim_page,
  output logic                       prim_pal_unused
);

  for (genvar s = 0; s < OUT_V; s++) begin : g_slot
    logic [1:0] src;
    assign src = 2'(s) + {1'b0, second};
    always_comb begin
      if (is_rect && s != 0) begin
        prim_xy[s*XY_W +: XY_W] = '0;
        prim_uv[s*UV_W +: UV_W] = '0;
      end else begin
        prim_xy[s*XY_W +: XY_W] = xy[src];
        prim_uv[s*UV_W +: UV_W] = uv[src];
      end
    end
  end

  assign prim_page       = is_rect ? page_cfg[EPAGE_W-1:0] : emb_page;
  assign prim_pal_unused = prim_page[EPAGE_W-1];

endmodule

// File: rtl/tex_cmd_decoder.sv
module tex_cmd_decoder
  import tcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_data,
  output logic        cmd_ready,
  output logic        prim_valid,
  input  logic        prim_ready,
  output logic [95:0] prim_xy,
  output logic [47:0] prim_uv,
  output logic [23:0] prim_color,
  output logic [15:0] prim_pal,
  output logic        prim_pal_unused,
  output logic [8:0]  prim_page,
  output logic        prim_semi,
  output logic        prim_rect,
  output logic        prim_second,
  output logic [31:0] prim_size,
  output logic [10:0] page_cfg,
  output logic [19:0] win_cfg
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                       in_idle;
  logic                       page_wr, poly_page_wr, win_wr;
  logic [EPAGE_W-1:0]         emb_page;
  logic [NVERT-1:0][XY_W-1:0] xy;
  logic [NVERT-1:0][UV_W-1:0] uv;

  tcd_collector u_coll (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cmd_valid    (cmd_valid),
    .cmd_data     (cmd_data),
    .cmd_ready    (cmd_ready),
    .prim_ready   (prim_ready),
    .in_idle      (in_idle),
    .emitting     (prim_valid),
    .second       (prim_second),
    .is_rect      (prim_rect),
    .semi         (prim_semi),
    .color        (prim_color),
    .pal          (prim_pal),
    .emb_page     (emb_page),
    .size         (prim_size),
    .xy           (xy),
    .uv           (uv),
    .page_wr      (page_wr),
    .poly_page_wr (poly_page_wr),
    .win_wr       (win_wr)
  );

  tcd_state_regs u_state (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .page_wr      (page_wr),
    .poly_page_wr (poly_page_wr),
    .win_wr       (win_wr),
    .page_data    (cmd_data[PAGE_W-1:0]),
    .poly_page    (cmd_data[16 +: EPAGE_W]),
    .win_data     (cmd_data[WIN_W-1:0]),
    .page_q       (page_cfg),
    .win_q        (win_cfg)
  );

  tcd_record_mux u_mux (
    .second          (prim_second),
    .is_rect         (prim_rect),
    .xy              (xy),
    .uv              (uv),
    .emb_page        (emb_page),
    .page_cfg        (page_cfg),
    .prim_xy         (prim_xy),
    .prim_uv         (prim_uv),
    .prim_page       (prim_page),
    .prim_pal_unused (prim_pal_unused)
  );

endmodule

// File: rtl/tcd_checker.sv
module tcd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_op,
  input logic [19:0] cmd_low,
  input logic        in_idle,
  input logic        prim_valid,
  input logic        prim_ready,
  input logic        prim_second,
  input logic [95:0] prim_xy,
  input logic [10:0] page_cfg,
  input logic [19:0] win_cfg
);

  logic lead, known;
  assign lead  = cmd_valid && cmd_ready && in_idle;
  assign known = (cmd_op == 8'h24) || (cmd_op == 8'h2C) || (cmd_op == 8'h2E) ||
                 (cmd_op == 8'h64) || (cmd_op == 8'h66) ||
                 (cmd_op == 8'hE1) || (cmd_op == 8'hE2);

  assert_ready_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid |-> !cmd_ready);

  assert_record_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid && !prim_ready |=> prim_valid && $stable(prim_xy) && $stable(prim_second));

  assert_page_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lead && cmd_op == 8'hE1 |=> page_cfg == $past(cmd_low[10:0]) && !prim_valid);

  assert_win_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lead && cmd_op == 8'hE2 |=> win_cfg == $past(cmd_low) && !prim_valid);

  assert_second_after_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prim_second) |-> $past(prim_valid && prim_ready));

  assert_unknown_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lead && !known |=> !prim_valid && $stable(page_cfg) && $stable(win_cfg));

endmodule

bind tex_cmd_decoder tcd_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_op      (cmd_data[31:24]),
  .cmd_low     (cmd_data[19:0]),
  .in_idle     (in_idle),
  .prim_valid  (prim_valid),
  .prim_ready  (prim_ready),
  .prim_second (prim_second),
  .prim_xy     (prim_xy),
  .page_cfg    (page_cfg),
  .win_cfg     (win_cfg)
);

// File: tb/tex_cmd_decoder_test.sv
`timescale 1ns/1ps
module tex_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [31:0] cmd_data;
  logic        cmd_ready;
  logic        prim_valid;
  logic        prim_ready;
  logic [95:0] prim_xy;
  logic [47:0] prim_uv;
  logic [23:0] prim_color;
  logic [15:0] prim_pal;
  logic        prim_pal_unused;
  logic [8:0]  prim_page;
  logic        prim_semi, prim_rect, prim_second;
  logic [31:0] prim_size;
  logic [10:0] page_cfg;
  logic [19:0] win_cfg;

  always #2.5 clk = ~clk;

  tex_cmd_decoder uut (.*);

  int checks = 0;
  int errors = 0;

  logic [10:0] page_m;
  logic [19:0] win_m;
  logic [31:0] vxy [4];
  logic [15:0] vuv [4];

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_rec(input string req, input logic second, input logic rect,
                            input logic semi, input logic [23:0] col,
                            input logic [15:0] pal, input logic [8:0] page,
                            input logic [31:0] size, input int stall);
    logic [95:0] exy;
    logic [47:0] euv;
    int n;
    n = 0;
    while (!prim_valid && n < 50) begin @(negedge clk); n++; end
    chk({req, " record present"}, 96'(prim_valid), 96'(1));
    if (rect) begin
      exy = {64'd0, vxy[0]};
      euv = {32'd0, vuv[0]};
    end else if (second) begin
      exy = {vxy[3], vxy[2], vxy[1]};
      euv = {vuv[3], vuv[2], vuv[1]};
    end else begin
      exy = {vxy[2], vxy[1], vxy[0]};
      euv = {vuv[2], vuv[1], vuv[0]};
    end
    chk({req, " xy"}, 96'(prim_xy), exy);
    chk({req, " uv"}, 96'(prim_uv), 96'(euv));
    chk({req, " color"}, 96'(prim_color), 96'(col));
    chk({req, " pal"}, 96'(prim_pal), 96'(pal));
    chk({req, " page"}, 96'(prim_page), 96'(page));
    chk("R9 pal_unused", 96'(prim_pal_unused), 96'(page[8]));
    chk("R5 semi", 96'(prim_semi), 96'(semi));
    chk({req, " rect flag"}, 96'(prim_rect), 96'(rect));
    chk("R3 second flag", 96'(prim_second), 96'(second));
    if (rect) chk("R4 size", 96'(prim_size), 96'(size));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R11 input blocked", 96'(cmd_ready), 96'(0));
      chk("R11 record held", 96'(prim_xy), exy);
    end
    prim_ready = 1'b1;
    @(negedge clk);
    prim_ready = 1'b0;
  endtask

  task automatic send_poly(input logic [7:0] op, input logic [23:0] col,
                           input logic [15:0] pal, input logic [15:0] epage, input int stall);
    int nv;
    nv = (op == 8'h24) ? 3 : 4;
    push({op, col});
    for (int k = 0; k < nv; k++) begin
      push(vxy[k]);
      push({(k == 0) ? pal : (k == 1) ? epage : 16'h0, vuv[k]});
    end
    page_m[8:0] = epage[8:0];
    expect_rec(op == 8'h24 ? "R2 tri" : "R3 quad", 1'b0, 1'b0, op[1], col, pal,
               epage[8:0], 32'd0, stall);
    if (nv == 4)
      expect_rec("R3 quad second", 1'b1, 1'b0, op[1], col, pal, epage[8:0], 32'd0, 0);
    chk("R8 page after polygon", 96'(page_cfg), 96'(page_m));
  endtask

  task automatic send_rect(input logic [7:0] op, input logic [23:0] col,
                           input logic [15:0] pal, input logic [31:0] size, input int stall);
    push({op, col});
    push(vxy[0]);
    push({pal, vuv[0]});
    push(size);
    expect_rec("R4 rect", 1'b0, 1'b1, op[1], col, pal, page_m[8:0], size, stall);
  endtask

  task automatic rand_verts();
    for (int k = 0; k < 4; k++) begin
      vxy[k] = $urandom;
      vuv[k] = 16'($urandom);
    end
  endtask

  function automatic bit is_known(input logic [7:0] op);
    return op == 8'h24 || op == 8'h2C || op == 8'h2E || op == 8'h64 ||
           op == 8'h66 || op == 8'hE1 || op == 8'hE2;
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] op;
    logic [31:0] w;
    int sel;
    void'($urandom(32'd20417));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0; prim_ready = 1'b0;
    page_m = '0; win_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready", 96'(cmd_ready), 96'(1));
    chk("R1 valid", 96'(prim_valid), 96'(0));
    chk("R1 page", 96'(page_cfg), 96'(0));
    chk("R1 window", 96'(win_cfg), 96'(0));

    // R6: all page bits, including dither and display-area drawing
    push(32'hE100_07A5);
    page_m = 11'h7A5;
    chk("R6 page write", 96'(page_cfg), 96'(page_m));
    chk("R6 no record", 96'(prim_valid), 96'(0));
    // R7
    push(32'hE20A_BCDE);
    win_m = 20'hABCDE;
    chk("R7 window write", 96'(win_cfg), 96'(win_m));

    // R2 + R8: triangle with direct-colour depth keeps bits 10..9
    rand_verts();
    send_poly(8'h24, 24'h808080, 16'h4020, 16'h0153, 0);
    chk("R8 upper bits kept", 96'(page_cfg[10:9]), 96'(2'b11));
    // R4: rectangle picks up the page left by the triangle, stalled output (R11)
    rand_verts();
    send_rect(8'h64, 24'h123456, 16'h4010, 32'h0010_0020, 5);
    // R3 + R5: semi-transparent quad with stall
    rand_verts();
    send_poly(8'h2E, 24'h0A0B0C, 16'h0001, 16'h0080, 3);
    // R10: unknown word
    push(32'h02FF_FFFF);
    repeat (2) @(negedge clk);
    chk("R10 no record", 96'(prim_valid), 96'(0));
    chk("R10 page unchanged", 96'(page_cfg), 96'(page_m));
    chk("R10 window unchanged", 96'(win_cfg), 96'(win_m));

    for (int it = 0; it < 150; it++) begin
      sel = $urandom_range(0, 7);
      rand_verts();
      w = $urandom;
      case (sel)
        0: send_poly(8'h24, 24'(w), 16'($urandom), 16'($urandom), $urandom_range(0, 2));
        1: send_poly(8'h2C, 24'(w), 16'($urandom), 16'($urandom), $urandom_range(0, 2));
        2: send_poly(8'h2E, 24'(w), 16'($urandom), 16'($urandom), 0);
        3: send_rect(8'h64, 24'(w), 16'($urandom), $urandom, $urandom_range(0, 2));
        4: send_rect(8'h66, 24'(w), 16'($urandom), $urandom, 0);
        5: begin
          push({8'hE1, w[23:0]});
          page_m = w[10:0];
          chk("R6 page write", 96'(page_cfg), 96'(page_m));
        end
        6: begin
          push({8'hE2, w[23:0]});
          win_m = w[19:0];
          chk("R7 window write", 96'(win_cfg), 96'(win_m));
        end
        default: begin
          op = 8'($urandom);
          while (is_known(op)) op = 8'($urandom);
          push({op, w[23:0]});
          @(negedge clk);
          chk("R10 no record", 96'(prim_valid), 96'(0));
          chk("R10 state unchanged", 96'({page_cfg, win_cfg}), 96'({page_m, win_m}));
        end
      endcase
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule